// File: doc/BRIEF.md
# DRAM Bank Type and Size Probe Sequencer

This block runs on its own once reset is released and works out what memory is fitted in each of eight banks. Bank by bank it writes and reads back a pattern over the first eight byte offsets, trying the access modes in a fixed order. It tries extended-data-out first, then fast-page, then synchronous. If every byte matches in one mode, the bank has that type. If only some bytes match, the bank mixes device types and is switched off. If nothing matches in any mode, the bank is empty.

For a populated bank, the sequencer then finds the real size. It writes a tag at the bank base. It then writes a distinct tag at each power-of-two offset in turn and reads the base back after each one. The first offset whose write disturbs the base gives the size. If no offset disturbs the base, the bank has the largest size.

Each bank gets an ending address equal to the running total of populated sizes, so address ranges climb with the bank index. When the last bank is done, a done flag rises and all configuration outputs freeze.

Top module: `dram_probe`

## Requirements
- R1: While reset is low, `probeDone`, `memReq`, `lastBank`, `bankType`, `bankEnd` and `rowOff` are all zero.
- R2: Type codes are 2'b00 empty, 2'b01 fast-page, 2'b10 extended-data-out and 2'b11 synchronous. `memMode` uses the same codes and is never 2'b00 during a request. Modes are tried in the order 2'b10, then 2'b01, then 2'b11. A bank whose eight test bytes all read back correctly in a mode gets that mode's code.
- R3: The type test writes 8'hA0+n to offset n, for n from 0 to 7, and reads it back. If only some of the eight bytes match in a mode, the bank gets `rowOff` set, type 2'b00, and no size probe. `rowOff` is never set for a bank with a non-zero type.
- R4: A populated bank has size 2^k bytes, where k is the smallest value from MIN_LOG2 to ADDR_W-1 for which writing at offset 2^k changes the byte at offset 0. If no such k exists, the size is 2^ADDR_W bytes.
- R5: `bankEnd` for bank b equals the end of bank b-1 plus the size of bank b in 2^MIN_LOG2-byte units; the end before bank 0 is zero. Empty and disabled banks repeat the previous end, so the ends never fall as the bank index rises.
- R6: While probing, `lastBank` equals the bank being tested, which is also `memBank` during every request. Once done, it holds the highest populated bank, or 0 if no bank is populated.
- R7: `memReq` stays high with bank, address, mode, direction and write data held steady until `memDone` or a timeout. It is low for at least one cycle after each completed request.
- R8: A request that gets no `memDone` ends after TIMEOUT_CYC cycles with `memReq` high, and a read that ends this way counts as a miscompare.
- R9: `probeDone` rises after bank NUM_BANKS-1 has been handled. From then on it stays high, `memReq` stays low, and every configuration output keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memReq | output | 1 | Memory request, held until done or timeout |
| memWrite | output | 1 | 1 = write, 0 = read |
| memMode | output | 2 | Access mode code for the request |
| memBank | output | BANK_W (3) | Bank addressed by the request |
| memAddr | output | ADDR_W (8) | Byte offset within the bank |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid with `memDone` |
| memDone | input | 1 | One-cycle completion strobe |
| probeDone | output | 1 | All banks characterised |
| lastBank | output | BANK_W (3) | Bank under test, or highest populated bank once done |
| bankType | output | 2*NUM_BANKS (16) | Per-bank type code, bank b at bits [2b+1:2b] |
| bankEnd | output | END_W*NUM_BANKS (64) | Per-bank ending address in 2^MIN_LOG2-byte units |
| rowOff | output | NUM_BANKS (8) | Per-bank disable for mixed device types |

## Verification
The properties assume that the memory side raises `memDone` only while `memReq` is high, for exactly one cycle, with read data valid in that same cycle. They also assume it never answers a request that is already finished. The bench's bank models are set at the falling edge. Each model waits a fixed latency after it sees a request, pulses `memDone` once, and clears it at the next falling edge. A model for an empty region stays silent, so the timeout path is exercised without ever breaking these assumptions.

// File: rtl/dram_probe_pkg.sv
package dram_probe_pkg;

  localparam int PROBE_BYTES = 8;
  localparam logic [7:0] BASE_TAG = 8'h5A;

  typedef enum logic [1:0] {
    KIND_EMPTY = 2'b00,
    KIND_FPM   = 2'b01,
    KIND_EDO   = 2'b10,
    KIND_SYNC  = 2'b11
  } dram_kind_e;

  typedef enum logic [2:0] {
    OP_TYPE_WR,
    OP_TYPE_RD,
    OP_BASE_WR,
    OP_BOUND_WR,
    OP_BASE_RD
  } probe_op_e;

  typedef enum logic [2:0] {
    ST_TYPE_WR,
    ST_TYPE_RD,
    ST_TYPE_EVAL,
    ST_SIZE_BASE,
    ST_SIZE_WR,
    ST_SIZE_RD,
    ST_ADVANCE,
    ST_HALT
  } probe_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      issue;
    probe_op_e op;
    logic      incByte;
    logic      clrTest;
    logic      advMode;
    logic      rstStep;
    logic      incStep;
    logic      commitPop;
    logic      fullSize;
    logic      commitVoid;
    logic      markOff;
    logic      nextBank;
    logic      finish;
  } probe_ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic ack;
    logic readOk;
    logic byteLast;
    logic allMatch;
    logic anyMatch;
    logic modeLast;
    logic stepLast;
    logic bankLast;
  } probe_stat_t;

  function automatic logic [7:0] typePattern(input logic [2:0] idx);
    return {5'b10100, idx};
  endfunction

  function automatic logic [7:0] boundTag(input logic [7:0] step);
    return 8'h80 | step;
  endfunction

endpackage

// File: rtl/dram_probe_ctrl.sv
module dram_probe_ctrl
  import dram_probe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  probe_stat_t stat,
  output probe_ctrl_t ctl
);

  probe_state_e state, stateNxt;
  logic waitAck, waitNxt;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    unique case (state)
      ST_TYPE_WR: begin
        if (!waitAck) begin
          ctl.issue = 1'b1;
          ctl.op    = OP_TYPE_WR;
        end else if (stat.ack) begin
          stateNxt = ST_TYPE_RD;
        end
      end
      ST_TYPE_RD: begin
        if (!waitAck) begin
          ctl.issue = 1'b1;
          ctl.op    = OP_TYPE_RD;
        end else if (stat.ack) begin
          if (stat.byteLast) begin
            stateNxt = ST_TYPE_EVAL;
          end else begin
            ctl.incByte = 1'b1;
            stateNxt    = ST_TYPE_WR;
          end
        end
      end
      ST_TYPE_EVAL: begin
        if (stat.allMatch) begin
          ctl.rstStep = 1'b1;
          stateNxt    = ST_SIZE_BASE;
        end else if (stat.anyMatch) begin
          ctl.commitVoid = 1'b1;
          ctl.markOff    = 1'b1;
          stateNxt       = ST_ADVANCE;
        end else if (stat.modeLast) begin
          ctl.commitVoid = 1'b1;
          stateNxt       = ST_ADVANCE;
        end else begin
          ctl.advMode = 1'b1;
          ctl.clrTest = 1'b1;
          stateNxt    = ST_TYPE_WR;
        end
      end
      ST_SIZE_BASE: begin
        if (!waitAck) begin
          ctl.issue = 1'b1;
          ctl.op    = OP_BASE_WR;
        end else if (stat.ack) begin
          stateNxt = ST_SIZE_WR;
        end
      end
      ST_SIZE_WR: begin
        if (!waitAck) begin
          ctl.issue = 1'b1;
          ctl.op    = OP_BOUND_WR;
        end else if (stat.ack) begin
          stateNxt = ST_SIZE_RD;
        end
      end
      ST_SIZE_RD: begin
        if (!waitAck) begin
          ctl.issue = 1'b1;
          ctl.op    = OP_BASE_RD;
        end else if (stat.ack) begin
          if (!stat.readOk) begin
            ctl.commitPop = 1'b1;
            stateNxt      = ST_ADVANCE;
          end else if (stat.stepLast) begin
            ctl.commitPop = 1'b1;
            ctl.fullSize  = 1'b1;
            stateNxt      = ST_ADVANCE;
          end else begin
            ctl.incStep = 1'b1;
            stateNxt    = ST_SIZE_WR;
          end
        end
      end
      ST_ADVANCE: begin
        if (stat.bankLast) begin
          ctl.finish = 1'b1;
          stateNxt   = ST_HALT;
        end else begin
          ctl.nextBank = 1'b1;
          stateNxt     = ST_TYPE_WR;
        end
      end
      default: stateNxt = ST_HALT;
    endcase
  end

  always_comb begin
    waitNxt = waitAck;
    if (ctl.issue)     waitNxt = 1'b1;
    else if (stat.ack) waitNxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_TYPE_WR;
      waitAck <= 1'b0;
    end else begin
      state   <= stateNxt;
      waitAck <= waitNxt;
    end
  end

endmodule

// File: rtl/dram_probe_dp.sv
module dram_probe_dp
  import dram_probe_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int ADDR_W      = 8,
  parameter int MIN_LOG2    = 4,
  parameter int TIMEOUT_CYC = 16,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int END_W      = ADDR_W - MIN_LOG2 + BANK_W + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  probe_ctrl_t                 ctl,
  output probe_stat_t                 stat,
  output logic                        memReq,
  output logic                        memWrite,
  output logic [1:0]                  memMode,
  output logic [BANK_W-1:0]           memBank,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [7:0]                  memWdata,
  input  logic [7:0]                  memRdata,
  input  logic                        memDone,
  output logic                        probeDone,
  output logic [BANK_W-1:0]           lastBank,
  output logic [2*NUM_BANKS-1:0]      bankType,
  output logic [END_W*NUM_BANKS-1:0]  bankEnd,
  output logic [NUM_BANKS-1:0]        rowOff
);

  localparam int SZ_W  = $clog2(ADDR_W + 1);
  localparam int TMR_W = $clog2(TIMEOUT_CYC) + 1;

  logic [BANK_W-1:0]      bankIdx, hiPop;
  logic [2:0]             byteIdx;
  dram_kind_e             modeTry;
  logic [PROBE_BYTES-1:0] matchMask;
  logic [SZ_W-1:0]        sizeLog;
  probe_op_e              opReg;
  logic                   busy;
  logic [TMR_W-1:0]       timer;
  logic [END_W-1:0]       runEnd;
  dram_kind_e             typeReg [NUM_BANKS];
  logic [END_W-1:0]       endReg  [NUM_BANKS];
  logic [NUM_BANKS-1:0]   offReg;
  logic                   doneReg;

  logic [7:0]       expData;
  logic             timedOut, ack, readOk;
  logic [SZ_W-1:0]  shiftAmt;
  logic [END_W-1:0] nextEnd;

  always_comb begin
    expData  = (opReg == OP_BASE_RD) ? BASE_TAG : typePattern(byteIdx);
    timedOut = busy && (timer == TMR_W'(TIMEOUT_CYC - 1));
    ack      = busy && (memDone || timedOut);
    readOk   = memDone && (memRdata == expData);
    shiftAmt = ctl.fullSize ? SZ_W'(ADDR_W - MIN_LOG2) : (sizeLog - SZ_W'(MIN_LOG2));
    nextEnd  = runEnd + (END_W'(1) << shiftAmt);
  end

  always_comb begin
    stat.ack      = ack;
    stat.readOk   = readOk;
    stat.byteLast = (byteIdx == 3'd7);
    stat.allMatch = &matchMask;
    stat.anyMatch = |matchMask;
    stat.modeLast = (modeTry == KIND_SYNC);
    stat.stepLast = (sizeLog == SZ_W'(ADDR_W - 1));
    stat.bankLast = (bankIdx == BANK_W'(NUM_BANKS - 1));
  end

  // request fields come straight from counters that only move while idle
  always_comb begin
    memReq   = busy;
    memWrite = (opReg == OP_TYPE_WR) || (opReg == OP_BASE_WR) || (opReg == OP_BOUND_WR);
    memMode  = modeTry;
    memBank  = bankIdx;
    unique case (opReg)
      OP_TYPE_WR, OP_TYPE_RD: memAddr = ADDR_W'(byteIdx);
      OP_BOUND_WR:            memAddr = ADDR_W'(1) << sizeLog;
      default:                memAddr = '0;
    endcase
    unique case (opReg)
      OP_TYPE_WR:  memWdata = typePattern(byteIdx);
      OP_BASE_WR:  memWdata = BASE_TAG;
      OP_BOUND_WR: memWdata = boundTag(8'(sizeLog));
      default:     memWdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankIdx   <= '0;
      hiPop     <= '0;
      byteIdx   <= '0;
      modeTry   <= KIND_EDO;
      matchMask <= '0;
      sizeLog   <= SZ_W'(MIN_LOG2);
      opReg     <= OP_TYPE_WR;
      busy      <= 1'b0;
      timer     <= '0;
      runEnd    <= '0;
      offReg    <= '0;
      doneReg   <= 1'b0;
      for (int k = 0; k < NUM_BANKS; k++) begin
        typeReg[k] <= KIND_EMPTY;
        endReg[k]  <= '0;
      end
    end else begin
      if (ctl.issue) begin
        opReg <= ctl.op;
        busy  <= 1'b1;
        timer <= '0;
      end else if (ack) begin
        busy <= 1'b0;
      end else if (busy) begin
        timer <= timer + 1'b1;
      end

      if (ack && opReg == OP_TYPE_RD) matchMask[byteIdx] <= readOk;

      if (ctl.clrTest || ctl.nextBank) begin
        byteIdx   <= '0;
        matchMask <= '0;
      end else if (ctl.incByte) begin
        byteIdx <= byteIdx + 1'b1;
      end

      if (ctl.nextBank) begin
        modeTry <= KIND_EDO;
        bankIdx <= bankIdx + 1'b1;
      end else if (ctl.advMode) begin
        unique case (modeTry)
          KIND_EDO: modeTry <= KIND_FPM;
          KIND_FPM: modeTry <= KIND_SYNC;
          default:  modeTry <= modeTry;
        endcase
      end

      if (ctl.rstStep)      sizeLog <= SZ_W'(MIN_LOG2);
      else if (ctl.incStep) sizeLog <= sizeLog + 1'b1;

      if (ctl.commitPop) begin
        typeReg[bankIdx] <= modeTry;
        endReg[bankIdx]  <= nextEnd;
        runEnd           <= nextEnd;
        hiPop            <= bankIdx;
      end else if (ctl.commitVoid) begin
        typeReg[bankIdx] <= KIND_EMPTY;
        endReg[bankIdx]  <= runEnd;
        offReg[bankIdx]  <= ctl.markOff;
      end

      if (ctl.finish) doneReg <= 1'b1;
    end
  end

  assign probeDone = doneReg;
  assign lastBank  = doneReg ? hiPop : bankIdx;
  assign rowOff    = offReg;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : gFlat
    assign bankType[2*k +: 2]     = typeReg[k];
    assign bankEnd[END_W*k +: END_W] = endReg[k];
  end

endmodule

// File: rtl/dram_probe.sv
module dram_probe
  import dram_probe_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int ADDR_W      = 8,
  parameter int MIN_LOG2    = 4,
  parameter int TIMEOUT_CYC = 16,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int END_W      = ADDR_W - MIN_LOG2 + BANK_W + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  output logic                        memReq,
  output logic                        memWrite,
  output logic [1:0]                  memMode,
  output logic [BANK_W-1:0]           memBank,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [7:0]                  memWdata,
  input  logic [7:0]                  memRdata,
  input  logic                        memDone,
  output logic                        probeDone,
  output logic [BANK_W-1:0]           lastBank,
  output logic [2*NUM_BANKS-1:0]      bankType,
  output logic [END_W*NUM_BANKS-1:0]  bankEnd,
  output logic [NUM_BANKS-1:0]        rowOff
);

  probe_ctrl_t ctl;
  probe_stat_t stat;

  dram_probe_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .ctl  (ctl)
  );

  dram_probe_dp #(
    .NUM_BANKS  (NUM_BANKS),
    .ADDR_W     (ADDR_W),
    .MIN_LOG2   (MIN_LOG2),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .stat     (stat),
    .memReq   (memReq),
    .memWrite (memWrite),
    .memMode  (memMode),
    .memBank  (memBank),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .memDone  (memDone),
    .probeDone(probeDone),
    .lastBank (lastBank),
    .bankType (bankType),
    .bankEnd  (bankEnd),
    .rowOff   (rowOff)
  );

endmodule

// File: rtl/dram_probe_checker.sv
module dram_probe_checker #(
  parameter int NUM_BANKS   = 8,
  parameter int ADDR_W      = 8,
  parameter int MIN_LOG2    = 4,
  parameter int TIMEOUT_CYC = 16,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int END_W      = ADDR_W - MIN_LOG2 + BANK_W + 1
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        memReq,
  input logic                        memWrite,
  input logic [1:0]                  memMode,
  input logic [BANK_W-1:0]           memBank,
  input logic [ADDR_W-1:0]           memAddr,
  input logic [7:0]                  memWdata,
  input logic                        memDone,
  input logic                        probeDone,
  input logic [BANK_W-1:0]           lastBank,
  input logic [2*NUM_BANKS-1:0]      bankType,
  input logic [END_W*NUM_BANKS-1:0]  bankEnd,
  input logic [NUM_BANKS-1:0]        rowOff
);

  localparam int AGE_W = $clog2(TIMEOUT_CYC) + 2;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  // consecutive cycles memReq has already been high before this one
  logic [AGE_W-1:0] reqAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 reqAge <= '0;
    else if (!memReq)          reqAge <= '0;
    else if (reqAge != AGE_MAX) reqAge <= reqAge + 1'b1;
  end

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memDone && reqAge < AGE_W'(TIMEOUT_CYC - 1)) |=>
      (memReq && $stable(memAddr) && $stable(memBank) && $stable(memMode)
       && $stable(memWrite) && $stable(memWdata)));

  assert_req_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memDone) |=> !memReq);

  assert_req_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (reqAge < AGE_W'(TIMEOUT_CYC)));

  assert_timeout_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && reqAge == AGE_W'(TIMEOUT_CYC - 1)) |=> !memReq);

  assert_mode_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memMode != 2'b00));

  assert_bank_tracks_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memBank == lastBank && !probeDone));

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    probeDone |=> (probeDone && !memReq && $stable(bankType) && $stable(bankEnd)
                   && $stable(rowOff) && $stable(lastBank)));

  for (genvar k = 0; k < NUM_BANKS; k++) begin : gBank
    assert_off_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
      rowOff[k] |-> (bankType[2*k +: 2] == 2'b00));
    if (k > 0) begin : gRise
      assert_end_rising_R5: assert property (@(posedge clk) disable iff (!rstN)
        probeDone |-> (bankEnd[END_W*k +: END_W] >= bankEnd[END_W*(k-1) +: END_W]));
    end
  end

endmodule

bind dram_probe dram_probe_checker #(
  .NUM_BANKS  (NUM_BANKS),
  .ADDR_W     (ADDR_W),
  .MIN_LOG2   (MIN_LOG2),
  .TIMEOUT_CYC(TIMEOUT_CYC)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .memReq   (memReq),
  .memWrite (memWrite),
  .memMode  (memMode),
  .memBank  (memBank),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memDone  (memDone),
  .probeDone(probeDone),
  .lastBank (lastBank),
  .bankType (bankType),
  .bankEnd  (bankEnd),
  .rowOff   (rowOff)
);

// File: tb/dram_probe_test.sv
`timescale 1ns/1ps
module dram_probe_test;

  localparam int NB     = 8;
  localparam int AW     = 8;
  localparam int MINL   = 4;
  localparam int TMO    = 16;
  localparam int BW     = 3;
  localparam int EW     = AW - MINL + BW + 1;
  localparam int LAT    = 2;

  // {modeLo[10:9], modeHi[8:7], sizeLog[6:3], expType[2:1], expOff[0]}
  localparam logic [10:0] RUN_A [NB] = '{
    {2'b10, 2'b10, 4'd6, 2'b10, 1'b0},
    {2'b01, 2'b01, 4'd4, 2'b01, 1'b0},
    {2'b00, 2'b00, 4'd4, 2'b00, 1'b0},
    {2'b11, 2'b11, 4'd8, 2'b11, 1'b0},
    {2'b10, 2'b01, 4'd5, 2'b00, 1'b1},
    {2'b11, 2'b00, 4'd5, 2'b00, 1'b1},
    {2'b01, 2'b01, 4'd7, 2'b01, 1'b0},
    {2'b00, 2'b00, 4'd4, 2'b00, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memReq, memWrite, memDone, probeDone;
  logic [1:0] memMode;
  logic [BW-1:0] memBank, lastBank;
  logic [AW-1:0] memAddr;
  logic [7:0] memWdata, memRdata;
  logic [2*NB-1:0] bankType;
  logic [EW*NB-1:0] bankEnd;
  logic [NB-1:0] rowOff;

  always #2.5 clk = ~clk;

  dram_probe uut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memWrite(memWrite),
    .memMode(memMode), .memBank(memBank), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memDone(memDone),
    .probeDone(probeDone), .lastBank(lastBank), .bankType(bankType),
    .bankEnd(bankEnd), .rowOff(rowOff)
  );

  int checks = 0;
  int fails  = 0;
  logic [1:0] cfgLo [NB];
  logic [1:0] cfgHi [NB];
  int         cfgSz [NB];
  logic [1:0] expType [NB];
  logic       expOff [NB];
  logic [7:0] mem [NB][256];
  int gapErr = 0;
  int maxRun = 0;

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  // behavioural banks, driven at the falling edge
  initial begin
    int lat = 0;
    int runLen = 0;
    memDone = 1'b0;
    memRdata = 8'h00;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        memDone = 1'b0; lat = 0; runLen = 0;
      end else begin
        if (memReq) runLen++; else runLen = 0;
        if (runLen > maxRun) maxRun = runLen;
        if (memDone && memReq) gapErr++;
        if (memDone) begin
          memDone = 1'b0;
        end else if (memReq) begin
          logic [1:0] m;
          int idx;
          m = (memAddr < 8 && memAddr[2]) ? cfgHi[memBank] : cfgLo[memBank];
          idx = int'(memAddr) & ((1 << cfgSz[memBank]) - 1);
          if (m != 2'b00) begin
            if (lat == LAT - 1) begin
              lat = 0;
              memDone = 1'b1;
              if (m == memMode) begin
                if (memWrite) mem[memBank][idx] = memWdata;
                else          memRdata = mem[memBank][idx];
              end else begin
                memRdata = 8'h3C;
              end
            end else begin
              lat++;
            end
          end
        end else begin
          lat = 0;
        end
      end
    end
  end

  task automatic startRun();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 done", int'(probeDone), 0);
    check("R1 req", int'(memReq), 0);
    check("R1 last", int'(lastBank), 0);
    check("R1 type", int'(bankType), 0);
    check("R1 end", int'(bankEnd != '0), 0);
    check("R1 off", int'(rowOff), 0);
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 256; i++) mem[b][i] = 8'h00;
    gapErr = 0;
    maxRun = 0;
    rstN = 1'b1;
  endtask

  task automatic waitDone();
    while (!probeDone) @(negedge clk);
  endtask

  task automatic checkBanks();
    int run = 0;
    int last = 0;
    for (int b = 0; b < NB; b++) begin
      check($sformatf("R2 type bank %0d", b), int'(bankType[2*b +: 2]), int'(expType[b]));
      check($sformatf("R3 off bank %0d", b), int'(rowOff[b]), int'(expOff[b]));
      if (!expOff[b] && expType[b] != 2'b00) begin
        run += 1 << (cfgSz[b] - MINL);
        last = b;
      end
      check($sformatf("R4 R5 end bank %0d", b), int'(bankEnd[EW*b +: EW]), run);
    end
    check("R6 final lastBank", int'(lastBank), last);
    check("R7 gap after done", gapErr, 0);
  endtask

  task automatic checkFrozen();
    logic [2*NB-1:0] t;
    logic [EW*NB-1:0] e;
    logic [NB-1:0] o;
    logic [BW-1:0] l;
    t = bankType; e = bankEnd; o = rowOff; l = lastBank;
    repeat (40) @(negedge clk);
    check("R9 done held", int'(probeDone), 1);
    check("R9 req low", int'(memReq), 0);
    check("R9 config held", int'(t == bankType && e == bankEnd && o == rowOff && l == lastBank), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // run A: table of mixed banks
    for (int b = 0; b < NB; b++) begin
      cfgLo[b]   = RUN_A[b][10:9];
      cfgHi[b]   = RUN_A[b][8:7];
      cfgSz[b]   = int'(RUN_A[b][6:3]);
      expType[b] = RUN_A[b][2:1];
      expOff[b]  = RUN_A[b][0];
    end
    startRun();
    while (!(memReq && memBank == 3'd3)) @(negedge clk);
    check("R6 lastBank during probe", int'(lastBank), 3);
    check("R9 not done mid-run", int'(probeDone), 0);
    waitDone();
    checkBanks();
    checkFrozen();

    // run B: nothing fitted, every access times out
    for (int b = 0; b < NB; b++) begin
      cfgLo[b] = 2'b00; cfgHi[b] = 2'b00; cfgSz[b] = 4;
      expType[b] = 2'b00; expOff[b] = 1'b0;
    end
    startRun();
    waitDone();
    checkBanks();
    check("R8 timeout length", maxRun, TMO);

    // run C: all banks extended-data-out at the largest size
    for (int b = 0; b < NB; b++) begin
      cfgLo[b] = 2'b10; cfgHi[b] = 2'b10; cfgSz[b] = AW;
      expType[b] = 2'b10; expOff[b] = 1'b0;
    end
    startRun();
    waitDone();
    checkBanks();
    check("R4 R5 top end", int'(bankEnd[EW*(NB-1) +: EW]), NB << (AW - MINL));
    check("R8 no timeout when answered", int'(maxRun <= LAT + 1), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule